// File: doc/BRIEF.md
# USB Transmit Bit Serializer

This block turns a stream of parallel bytes from a USB link into the serial symbol stream that drives the line. A byte is accepted over a valid/ready handshake. Its ready output is meant to drive the interface's "next byte" strobe directly, so the block throttles the link with its own busy state and holds no FIFO. Bits leave least significant first. After six consecutive ones a zero is stuffed. The result is NRZI-encoded from the idle J state, and the line moves one symbol per cycle in which the bit-clock enable is high.

A packet whose first byte is flagged as carrying a PID is framed. It gets a start-of-packet synchronisation pattern and an end-of-packet pattern, and both depend on the speed sampled with the first byte. Full speed uses an 8-bit pattern and an EOP of two SE0 bit times then one J. High speed uses a 32-bit pattern and an EOP of eight NRZI bits (a zero then seven ones) that are exempt from stuffing. An unflagged packet is sent as plain stuffed, NRZI-encoded bits with no framing. A packet ends when the link has no byte to offer at a byte boundary. CRC bytes, if any, come from the link as ordinary data.

Top module: `usb_tx_serializer`

## Requirements
- R1: After reset and between packets the outputs show idle: tx_active=0, line_se0=0, line_j=1 (J), and in_ready=1.
- R2: A flagged packet in full-speed mode (hs_mode=0 at the first byte) starts with the line states K J K J K J K K.
- R3: A flagged packet in high-speed mode (hs_mode=1 at the first byte) starts with 31 alternating states beginning with K, followed by a repeat of the 31st state: 31 data zeros then a one.
- R4: Each byte is sent least significant bit first.
- R5: After six consecutive data ones (the last synchronisation bit counts), one zero is inserted before the next symbol, including before an EOP or before returning to idle. The inserted zero restarts the count.
- R6: Encoding is NRZI: a data zero toggles the line, a data one holds it. The reference is J at the start of every packet.
- R7: A full-speed flagged packet ends with two SE0 symbols (line_se0=1, line_j=0, tx_active=1) and then one J symbol with tx_active=1, after which the outputs go idle.
- R8: A high-speed flagged packet ends with eight NRZI symbols encoding a zero then seven ones, with no bit inserted among them.
- R9: An unflagged packet (in_pid=0 at the first byte) has neither synchronisation pattern nor EOP. Its first data bit is the first active symbol.
- R10: in_ready is high in idle, and otherwise only in the enabled cycle that sends bit 7 of a byte. It is never high while an inserted zero is pending. With the enable high every cycle, the second byte is taken one cycle after the first byte's bit 7 is sent.
- R11: If in_valid is low when in_ready is high at a byte boundary, the packet ends (EOP if flagged) and the line returns to idle.
- R12: line_j, line_se0 and tx_active change only on clock edges where bit_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-clock enable; one line symbol per enabled edge |
| hs_mode | input | 1 | 1 selects high-speed framing; sampled with the first byte |
| in_valid | input | 1 | Link has a byte on in_data |
| in_data | input | BYTE_W (8) | Byte to transmit |
| in_pid | input | 1 | First byte carries a PID, so frame the packet; sampled with the first byte |
| in_ready | output | 1 | Byte taken when high together with in_valid; drives the next-byte strobe |
| line_j | output | 1 | Line state: 1 = J, 0 = K (0 during SE0) |
| line_se0 | output | 1 | Current symbol is single-ended zero |
| tx_active | output | 1 | A packet symbol is on the line |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a stuffing limit of six, 8- and 32-bit synchronisation patterns, and high-speed framing enabled. These values bring both framing variants into reach, along with a stuffed zero that lands inside the synchronisation tail, in mid-byte, and just before an EOP or idle. With the enable high every cycle the byte-to-byte acceptance spacing can be checked exactly. A run with the enable high one cycle in three shows that the outputs hold between enabled edges.

// File: rtl/usbtx_pkg.sv
`timescale 1ns/1ps
package usbtx_pkg;

   // Kind of symbol placed on the line in one bit time
   typedef enum logic [2:0] {
      SYM_IDLE = 3'd0,   // bus idle, J, not part of a packet
      SYM_DATA = 3'd1,   // NRZI bit that counts toward stuffing
      SYM_RAW  = 3'd2,   // NRZI bit exempt from stuffing
      SYM_SE0  = 3'd3,   // single-ended zero
      SYM_J    = 3'd4    // forced J inside a packet
   } sym_kind_e;

   typedef struct packed {
      sym_kind_e kind;
      logic      val;
   } sym_t;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_SYNC = 2'd1,
      FR_DATA = 2'd2,
      FR_EOP  = 2'd3
   } fr_state_e;

endpackage

// File: rtl/usbtx_framer.sv
`timescale 1ns/1ps
module usbtx_framer
   import usbtx_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter int FS_SYNC_BITS = 8,
   parameter int HS_SYNC_BITS = 32,
   parameter int FS_EOP_SE0   = 2,
   parameter int HS_EOP_BITS  = 8,
   parameter bit HS_ENABLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              hold,
   input  logic              hs_mode,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_pid,
   output logic              in_ready,
   output sym_t              sym,
   output logic              busy
);

   localparam int SPAN_SYNC = (FS_SYNC_BITS > HS_SYNC_BITS) ? FS_SYNC_BITS : HS_SYNC_BITS;
   localparam int SPAN_EOP  = (HS_EOP_BITS > FS_EOP_SE0 + 1) ? HS_EOP_BITS : FS_EOP_SE0 + 1;
   localparam int SPAN_A    = (SPAN_SYNC > SPAN_EOP) ? SPAN_SYNC : SPAN_EOP;
   localparam int CNT_SPAN  = (SPAN_A > BYTE_W) ? SPAN_A : BYTE_W;
   localparam int CNT_W     = $clog2(CNT_SPAN);

   localparam logic [CNT_W-1:0] BYTE_LAST    = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FS_SYNC_LAST = CNT_W'(FS_SYNC_BITS - 1);
   localparam logic [CNT_W-1:0] HS_SYNC_LAST = CNT_W'(HS_SYNC_BITS - 1);
   localparam logic [CNT_W-1:0] FS_EOP_LAST  = CNT_W'(FS_EOP_SE0);
   localparam logic [CNT_W-1:0] HS_EOP_LAST  = CNT_W'(HS_EOP_BITS - 1);
   localparam logic [CNT_W-1:0] SE0_SPAN     = CNT_W'(FS_EOP_SE0);

   fr_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic              hs_q;
   logic              pid_q;
   logic              hs_eff;
   logic              step;
   logic              slot;
   logic [CNT_W-1:0]  sync_last;
   logic [CNT_W-1:0]  eop_last;

   generate
      if (HS_ENABLE) begin : g_hs
         assign hs_eff = hs_mode;
      end else begin : g_fs_only
         logic unused_hs;
         assign unused_hs = hs_mode;
         assign hs_eff    = 1'b0;
      end
   endgenerate

   assign step      = bit_en & ~hold;
   assign slot      = (state_q == FR_DATA) && (cnt_q == BYTE_LAST) && step;
   assign in_ready  = ((state_q == FR_IDLE) && !hold) || slot;
   assign sync_last = hs_q ? HS_SYNC_LAST : FS_SYNC_LAST;
   assign eop_last  = hs_q ? HS_EOP_LAST  : FS_EOP_LAST;
   assign busy      = (state_q != FR_IDLE);

   always_comb begin
      sym = '{kind: SYM_IDLE, val: 1'b1};
      unique case (state_q)
         FR_IDLE: sym = '{kind: SYM_IDLE, val: 1'b1};
         FR_SYNC: sym = '{kind: SYM_DATA, val: (cnt_q == sync_last)};
         FR_DATA: sym = '{kind: SYM_DATA, val: sh_q[0]};
         FR_EOP: begin
            if (hs_q)
               sym = '{kind: SYM_RAW, val: (cnt_q != '0)};
            else if (cnt_q < SE0_SPAN)
               sym = '{kind: SYM_SE0, val: 1'b0};
            else
               sym = '{kind: SYM_J, val: 1'b1};
         end
         default: sym = '{kind: SYM_IDLE, val: 1'b1};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FR_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         hs_q    <= 1'b0;
         pid_q   <= 1'b0;
      end else begin
         unique case (state_q)
            FR_IDLE: begin
               if (in_valid && !hold) begin
                  sh_q    <= in_data;
                  hs_q    <= hs_eff;
                  pid_q   <= in_pid;
                  cnt_q   <= '0;
                  state_q <= in_pid ? FR_SYNC : FR_DATA;
               end
            end
            FR_SYNC: begin
               if (step) begin
                  if (cnt_q == sync_last) begin
                     cnt_q   <= '0;
                     state_q <= FR_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            FR_DATA: begin
               if (step) begin
                  if (cnt_q == BYTE_LAST) begin
                     cnt_q <= '0;
                     if (in_valid) sh_q <= in_data;
                     else          state_q <= pid_q ? FR_EOP : FR_IDLE;
                  end else begin
                     sh_q  <= sh_q >> 1;
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            FR_EOP: begin
               if (step) begin
                  if (cnt_q == eop_last) begin
                     cnt_q   <= '0;
                     state_q <= FR_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= FR_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/usbtx_stuffer.sv
`timescale 1ns/1ps
module usbtx_stuffer
   import usbtx_pkg::*;
#(
   parameter int STUFF_AFTER = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  sym_t sym_in,
   output sym_t sym_out,
   output logic hold
);

   localparam int               RUN_W   = $clog2(STUFF_AFTER + 1);
   localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(STUFF_AFTER);

   logic [RUN_W-1:0] run_q;

   assign hold = (run_q == RUN_LIM);

   always_comb begin
      sym_out = sym_in;
      if (hold) sym_out = '{kind: SYM_DATA, val: 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (bit_en)
         run_q <= (sym_out.kind == SYM_DATA && sym_out.val) ? run_q + 1'b1 : '0;
   end

endmodule

// File: rtl/usbtx_line_enc.sv
`timescale 1ns/1ps
module usbtx_line_enc
   import usbtx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  sym_t sym,
   output logic line_j,
   output logic line_se0,
   output logic tx_active
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_j    <= 1'b1;
         line_se0  <= 1'b0;
         tx_active <= 1'b0;
      end else if (bit_en) begin
         unique case (sym.kind)
            SYM_DATA, SYM_RAW: begin
               line_j    <= sym.val ? line_j : ~line_j;
               line_se0  <= 1'b0;
               tx_active <= 1'b1;
            end
            SYM_SE0: begin
               line_j    <= 1'b0;
               line_se0  <= 1'b1;
               tx_active <= 1'b1;
            end
            SYM_J: begin
               line_j    <= 1'b1;
               line_se0  <= 1'b0;
               tx_active <= 1'b1;
            end
            default: begin
               line_j    <= 1'b1;
               line_se0  <= 1'b0;
               tx_active <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/usb_tx_serializer.sv
`timescale 1ns/1ps
module usb_tx_serializer
   import usbtx_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter int STUFF_AFTER  = 6,
   parameter int FS_SYNC_BITS = 8,
   parameter int HS_SYNC_BITS = 32,
   parameter int FS_EOP_SE0   = 2,
   parameter int HS_EOP_BITS  = 8,
   parameter bit HS_ENABLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              hs_mode,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_pid,
   output logic              in_ready,
   output logic              line_j,
   output logic              line_se0,
   output logic              tx_active
);

   generate
      if (BYTE_W < 2)       begin : g_bad_byte  $error("BYTE_W must be at least 2");       end
      if (STUFF_AFTER < 1)  begin : g_bad_stuff $error("STUFF_AFTER must be at least 1");  end
      if (FS_SYNC_BITS < 2) begin : g_bad_fs    $error("FS_SYNC_BITS must be at least 2"); end
      if (HS_SYNC_BITS < 2) begin : g_bad_hs    $error("HS_SYNC_BITS must be at least 2"); end
      if (FS_EOP_SE0 < 1)   begin : g_bad_se0   $error("FS_EOP_SE0 must be at least 1");   end
      if (HS_EOP_BITS < 2)  begin : g_bad_heop  $error("HS_EOP_BITS must be at least 2");  end
   endgenerate

   sym_t fr_sym;
   sym_t st_sym;
   logic stuff_hold;
   logic fr_busy;

   usbtx_framer #(
      .BYTE_W       (BYTE_W),
      .FS_SYNC_BITS (FS_SYNC_BITS),
      .HS_SYNC_BITS (HS_SYNC_BITS),
      .FS_EOP_SE0   (FS_EOP_SE0),
      .HS_EOP_BITS  (HS_EOP_BITS),
      .HS_ENABLE    (HS_ENABLE)
   ) framer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .hold     (stuff_hold),
      .hs_mode  (hs_mode),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_pid   (in_pid),
      .in_ready (in_ready),
      .sym      (fr_sym),
      .busy     (fr_busy)
   );

   usbtx_stuffer #(
      .STUFF_AFTER (STUFF_AFTER)
   ) stuffer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .sym_in  (fr_sym),
      .sym_out (st_sym),
      .hold    (stuff_hold)
   );

   usbtx_line_enc line_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .sym       (st_sym),
      .line_j    (line_j),
      .line_se0  (line_se0),
      .tx_active (tx_active)
   );

endmodule

// File: rtl/usbtx_serializer_chk.sv
`timescale 1ns/1ps
module usbtx_serializer_chk
   import usbtx_pkg::*;
#(
   parameter int STUFF_AFTER = 6
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic in_ready,
   input logic line_j,
   input logic line_se0,
   input logic tx_active,
   input logic stuff_hold,
   input logic fr_busy,
   input sym_t st_sym
);

   // Run of consecutive stuffable ones seen leaving the stuffer
   int ones_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ones_run <= 0;
      else if (bit_en)
         ones_run <= (st_sym.kind == SYM_DATA && st_sym.val) ? ones_run + 1 : 0;
   end

   // R1: outside a packet the line rests in J
   a_r1_idle_is_j: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active |-> (line_j && !line_se0));

   // R5: never more than STUFF_AFTER stuffable ones in a row
   a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      ones_run <= STUFF_AFTER);

   // R7: the symbol after an SE0 run is J
   a_r7_se0_then_j: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_se0) |-> line_j);

   // R10: no byte is taken while a stuffed zero is pending
   a_r10_no_ready_on_stuff: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_hold |-> !in_ready);

   // R10: inside a packet a byte is taken only on an enabled edge
   a_r10_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && fr_busy) |-> bit_en);

   // R12: outputs hold across edges without the bit enable
   a_r12_hold_between_enables: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable({line_j, line_se0, tx_active}));

endmodule

bind usb_tx_serializer usbtx_serializer_chk #(
   .STUFF_AFTER (STUFF_AFTER)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_en     (bit_en),
   .in_ready   (in_ready),
   .line_j     (line_j),
   .line_se0   (line_se0),
   .tx_active  (tx_active),
   .stuff_hold (stuff_hold),
   .fr_busy    (fr_busy),
   .st_sym     (st_sym)
);

// File: tb/usb_tx_serializer_tb_top.sv
`timescale 1ns/1ps
module usb_tx_serializer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       hs_mode = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_pid = 1'b0;
   logic       in_ready;
   logic       line_j;
   logic       line_se0;
   logic       tx_active;

   always #2.5 clk = ~clk;

   usb_tx_serializer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .hs_mode   (hs_mode),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_pid    (in_pid),
      .in_ready  (in_ready),
      .line_j    (line_j),
      .line_se0  (line_se0),
      .tx_active (tx_active)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // Expected symbols: kind 0 stuffable data, 1 unstuffed bit, 2 SE0, 3 J
   logic [7:0] pk [0:7];
   int         sym_k [0:159];
   bit         sym_b [0:159];
   logic [2:0] expv  [0:159];   // {tx_active, line_se0, line_j}
   logic [2:0] cap   [0:159];
   int exp_n, sync_end, eop_start, l0, run;
   int g_ci, g_gap, g_changes;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expd);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expd);
      end
   endtask

   task automatic push(input int kind, input bit b);
      if (run == 6) begin
         sym_k[exp_n] = 0; sym_b[exp_n] = 1'b0; exp_n++; run = 0;
      end
      sym_k[exp_n] = kind; sym_b[exp_n] = b; exp_n++;
      run = (kind == 0 && b) ? run + 1 : 0;
   endtask

   task automatic build(input int n, input bit pid, input bit hs);
      bit j;
      exp_n = 0; run = 0; l0 = 0;
      if (pid) begin
         int sl;
         sl = hs ? 32 : 8;
         for (int i = 0; i < sl; i++) push(0, i == sl - 1);
      end
      sync_end = exp_n;
      for (int by = 0; by < n; by++)
         for (int bi = 0; bi < 8; bi++) begin
            push(0, pk[by][bi]);
            if (by == 0 && bi == 7) l0 = exp_n - 1;
         end
      eop_start = exp_n;
      if (pid && !hs) begin
         push(2, 1'b0); push(2, 1'b0); push(3, 1'b1);
      end else if (pid && hs) begin
         push(1, 1'b0);
         for (int i = 0; i < 7; i++) push(1, 1'b1);
      end else if (run == 6) begin
         sym_k[exp_n] = 0; sym_b[exp_n] = 1'b0; exp_n++; run = 0;
      end
      j = 1'b1;
      for (int i = 0; i < exp_n; i++) begin
         case (sym_k[i])
            0, 1: begin
               if (!sym_b[i]) j = ~j;
               expv[i] = {2'b10, j};
            end
            2: begin
               j = 1'b0;
               expv[i] = 3'b110;
            end
            default: begin
               j = 1'b1;
               expv[i] = 3'b101;
            end
         endcase
      end
      expv[exp_n] = 3'b001;
   endtask

   // Drives one packet and captures line symbols on enabled edges
   task automatic run_packet(input int n, input bit pid, input bit hs, input int div);
      int idx, cyc, phase, fire0, fire1, pre;
      bit capturing;
      logic [2:0] s, last_s;
      build(n, pid, hs);
      idx = 0; cyc = 0; phase = 0; fire0 = -1; fire1 = -1; pre = 4 * div + 2;
      capturing = 1'b0; g_ci = 0; g_changes = 0;
      last_s = {tx_active, line_se0, line_j};
      while (g_ci < exp_n + 1 && cyc < 3000) begin
         @(negedge clk);
         s = {tx_active, line_se0, line_j};
         if (bit_en) begin
            if (capturing || s[2]) begin
               capturing = 1'b1;
               cap[g_ci] = s;
               g_ci++;
            end
         end else if (s != last_s) begin
            g_changes++;
         end
         last_s   = s;
         bit_en   = (phase == 0);
         phase    = (phase + 1 == div) ? 0 : phase + 1;
         in_valid = (cyc >= pre) && (idx < n);
         in_data  = (idx < n) ? pk[idx] : 8'h00;
         in_pid   = pid;
         hs_mode  = hs;
         #1;
         if (in_valid && in_ready) begin
            if (idx == 0) fire0 = cyc;
            if (idx == 1) fire1 = cyc;
            idx++;
         end
         cyc++;
      end
      in_valid = 1'b0;
      g_gap = fire1 - fire0;
   endtask

   task automatic seg_check(input int lo, input int hi, input string tag, input string what);
      int bad;
      bad = -1;
      for (int i = lo; i < hi; i++)
         if (bad < 0 && cap[i] !== expv[i]) bad = i;
      n_checks++;
      if (bad >= 0) begin
         n_fail++;
         $display("FAIL %s %s: symbol %0d actual %b expected %b",
                  tag, what, bad, cap[bad], expv[bad]);
      end
   endtask

   task automatic check_complete(input string tag);
      check(g_ci == exp_n + 1, tag, "captured symbol count", g_ci, exp_n + 1);
   endtask

   task automatic test_reset;
      rst_n = 1'b0; bit_en = 1'b0; in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({tx_active, line_se0, line_j} == 3'b001, "R1", "idle line after reset",
            {tx_active, line_se0, line_j}, 3'b001);
      check(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
   endtask

   task automatic test_fs_basic;
      pk[0] = 8'hA5; pk[1] = 8'h3C;
      run_packet(2, 1'b1, 1'b0, 1);
      check_complete("R2");
      seg_check(0, sync_end, "R2", "full-speed sync pattern");
      seg_check(sync_end, eop_start, "R4", "bytes sent LSB first");
      seg_check(eop_start, exp_n + 1, "R7", "full-speed EOP and idle");
      check(g_gap == l0 + 1, "R10", "second byte acceptance spacing", g_gap, l0 + 1);
   endtask

   task automatic test_fs_stuffing;
      pk[0] = 8'hFF; pk[1] = 8'hFF; pk[2] = 8'h01;
      run_packet(3, 1'b1, 1'b0, 1);
      check_complete("R5");
      seg_check(sync_end, eop_start, "R5", "stuffed zeros in long ones run");
      check(g_gap == l0 + 1, "R10", "spacing delayed by stuffed bit", g_gap, l0 + 1);
      seg_check(eop_start, exp_n + 1, "R7", "EOP after stuffed payload");
   endtask

   task automatic test_hs_packet;
      pk[0] = 8'h69; pk[1] = 8'hFE;
      run_packet(2, 1'b1, 1'b1, 1);
      check_complete("R3");
      seg_check(0, sync_end, "R3", "high-speed sync pattern");
      seg_check(sync_end, eop_start, "R6", "NRZI payload at high speed");
      seg_check(eop_start, exp_n + 1, "R8", "high-speed EOP unstuffed");
      check(g_gap == l0 + 1, "R10", "high-speed byte spacing", g_gap, l0 + 1);
   endtask

   task automatic test_tail_stuff;
      pk[0] = 8'hFC;
      run_packet(1, 1'b1, 1'b0, 1);
      check_complete("R5");
      seg_check(eop_start, exp_n + 1, "R5", "stuffed zero ahead of EOP");
      seg_check(sync_end, eop_start, "R4", "single byte payload");
   endtask

   task automatic test_raw;
      pk[0] = 8'h0F; pk[1] = 8'hFC;
      run_packet(2, 1'b0, 1'b0, 1);
      check_complete("R9");
      seg_check(0, eop_start, "R9", "unframed packet bits");
      seg_check(eop_start, exp_n + 1, "R11", "end at byte boundary, stuff then idle");
   endtask

   task automatic test_slow_enable;
      pk[0] = 8'h5A; pk[1] = 8'h80;
      run_packet(2, 1'b1, 1'b0, 3);
      check_complete("R12");
      check(g_changes == 0, "R12", "output changes without enable", g_changes, 0);
      seg_check(0, exp_n + 1, "R6", "NRZI stream with sparse enable");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      test_reset();
      test_fs_basic();
      test_fs_stuffing();
      test_hs_packet();
      test_tail_stuff();
      test_raw();
      test_slow_enable();
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule